// File: doc/BRIEF.md
# Domain Access Control Checker

This block judges every translated memory access against a 32-bit control word that assigns one of four 2-bit modes to each of sixteen protection domains. Each translation entry carries a domain number and access-permission bits; the checker looks up the domain's mode and either refuses the access outright, waves it through without looking at the entry's permission bits, or defers to those bits. Because many regions can share a domain, rewriting the single control word changes the rights of all of them at once, without touching the translation tables.

When an access is refused the block raises a one-cycle abort and latches an 8-bit fault status word holding the domain number and a 4-bit fault code. The code tells apart a domain fault from a permission fault and a section-sized mapping from a page-sized one. Both the control word and the status word can be written through a simple write port.

Top module: `domain_guard`

## Requirements
- R1: After reset `abort` is low, `fault_status` is 0x00 and the control word is all zeros, so every domain starts in the blocking mode and any access aborts with a domain fault.
- R2: The mode of domain n is the control word field at bits 2n+1:2n; a write of 0xFFFFFFF3 blocks domain 1 only and leaves every other domain in manager mode.
- R3: Mode 0b00 (blocked): every valid access to that domain aborts with a domain fault, whatever the permission bits, privilege or direction.
- R4: Mode 0b10 (reserved) behaves exactly as mode 0b00.
- R5: Mode 0b11 (manager): no access to that domain aborts, whatever the permission bits, privilege or direction.
- R6: Mode 0b01 (client): the entry's 2-bit permission value decides: 0b11 allows everything; 0b10 allows privileged reads and writes and user reads only; 0b01 allows privileged accesses only; 0b00 allows nothing. A refused access aborts with a permission fault.
- R7: `fault_status` holds the domain number in bits 7:4 and a code in bits 3:0: 0x9 domain fault on a section, 0xB domain fault on a page, 0xD permission fault on a section, 0xF permission fault on a page (domain 1 blocked on a section gives 0x19).
- R8: An access presented with `acc_valid` high at a clock edge that faults raises `abort` for exactly the following cycle; with `acc_valid` low no abort is raised.
- R9: `fault_status` changes only when an abort is raised or when it is written through the port; a passing access leaves it unchanged.
- R10: With `cfg_wr` high and `cfg_sel` = 1, `cfg_wdata[7:0]` is loaded into `fault_status`; when an abort is captured in the same cycle, the captured fault wins.
- R11: With `cfg_wr` high and `cfg_sel` = 0, `cfg_wdata` replaces the control word; an access presented in the same cycle is judged with the old control word, and the new one applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_dom | input | 4 | Domain number of the translation entry |
| acc_ap | input | 2 | Access-permission bits of the entry |
| acc_priv | input | 1 | 1 = privileged access, 0 = user |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_page | input | 1 | 1 = translation hit a page, 0 = a section |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = fault status |
| cfg_wdata | input | 32 | Register write data |
| abort | output | 1 | One-cycle abort strobe |
| fault_status | output | 8 | Latched domain (7:4) and fault code (3:0) |

## Verification
Two functions can meet in one cycle: a register write and an access check. The bench provokes this by driving a control-word rewrite together with an access to the domain being changed, expecting the verdict of the old mode, and then repeating the access alone to see the new mode take hold. It also drives a status-word write together with a faulting access and expects the captured fault, not the written value, to be what `fault_status` holds afterwards.

// File: rtl/dg_pkg.sv
package dg_pkg;

    localparam int NUM_DOM = 16;
    localparam int FLD_W   = 2;
    localparam int DOM_W   = $clog2(NUM_DOM);
    localparam int CODE_W  = 4;
    localparam int CTRL_W  = NUM_DOM * FLD_W;
    localparam int STAT_W  = DOM_W + CODE_W;

    typedef enum logic [FLD_W-1:0] {
        MODE_BLOCK   = 2'b00,
        MODE_CLIENT  = 2'b01,
        MODE_RSVD    = 2'b10,
        MODE_MANAGER = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        AP_NONE  = 2'b00,
        AP_PRIV  = 2'b01,
        AP_UREAD = 2'b10,
        AP_FULL  = 2'b11
    } ap_e;

    typedef enum logic [CODE_W-1:0] {
        FC_DOM_SEC   = 4'h9,
        FC_DOM_PAGE  = 4'hB,
        FC_PERM_SEC  = 4'hD,
        FC_PERM_PAGE = 4'hF
    } fcode_e;

    typedef struct packed {
        logic [DOM_W-1:0] dom;
        ap_e              ap;
        logic             priv;
        logic             write;
        logic             page;
    } acc_req_t;

    typedef struct packed {
        logic             fault;
        logic [DOM_W-1:0] dom;
        fcode_e           code;
    } verdict_t;

    // Client-mode permission table
    function automatic logic ap_allows(ap_e ap, logic priv, logic write);
        logic ok;
        case (ap)
            AP_FULL:  ok = 1'b1;
            AP_UREAD: ok = priv | ~write;
            AP_PRIV:  ok = priv;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic fcode_e pick_code(logic dom_fault, logic page);
        fcode_e c;
        if (dom_fault) c = page ? FC_DOM_PAGE : FC_DOM_SEC;
        else           c = page ? FC_PERM_PAGE : FC_PERM_SEC;
        return c;
    endfunction

endpackage

// File: rtl/dg_ctrl_reg.sv
module dg_ctrl_reg
    import dg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst)        ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wdata;
    end

endmodule

// File: rtl/dg_domain_decode.sv
module dg_domain_decode
    import dg_pkg::*;
(
    input  logic              valid,
    input  acc_req_t          req,
    input  logic [CTRL_W-1:0] ctrl_q,
    output verdict_t          verdict
);

    dom_mode_e mode_arr [NUM_DOM];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
        assign mode_arr[g] = dom_mode_e'(ctrl_q[g*FLD_W +: FLD_W]);
    end

    dom_mode_e sel_mode;
    logic      dom_fault;
    logic      perm_fault;

    always_comb begin
        sel_mode   = mode_arr[req.dom];
        dom_fault  = 1'b0;
        perm_fault = 1'b0;
        case (sel_mode)
            MODE_BLOCK,
            MODE_RSVD:    dom_fault  = 1'b1;
            MODE_CLIENT:  perm_fault = ~ap_allows(req.ap, req.priv, req.write);
            default:      ;
        endcase
        verdict.fault = valid & (dom_fault | perm_fault);
        verdict.dom   = req.dom;
        verdict.code  = pick_code(dom_fault, req.page);
    end

endmodule

// File: rtl/dg_status.sv
module dg_status
    import dg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  verdict_t          verdict,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wdata,
    output logic              abort_q,
    output logic [STAT_W-1:0] stat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            abort_q <= 1'b0;
            stat_q  <= '0;
        end else begin
            abort_q <= verdict.fault;
            if (verdict.fault)
                stat_q <= {verdict.dom, verdict.code};
            else if (wr_en)
                stat_q <= wdata;
        end
    end

endmodule

// File: rtl/domain_guard.sv
module domain_guard
    import dg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [DOM_W-1:0]  acc_dom,
    input  logic [1:0]        acc_ap,
    input  logic              acc_priv,
    input  logic              acc_write,
    input  logic              acc_page,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic              abort,
    output logic [STAT_W-1:0] fault_status
);

    logic [CTRL_W-1:0] ctrl_q;
    acc_req_t          req;
    verdict_t          verdict;

    assign req = '{dom: acc_dom, ap: ap_e'(acc_ap), priv: acc_priv,
                   write: acc_write, page: acc_page};

    dg_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr & ~cfg_sel),
        .wdata  (cfg_wdata),
        .ctrl_q (ctrl_q)
    );

    dg_domain_decode u_dec (
        .valid   (acc_valid),
        .req     (req),
        .ctrl_q  (ctrl_q),
        .verdict (verdict)
    );

    dg_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .verdict (verdict),
        .wr_en   (cfg_wr & cfg_sel),
        .wdata   (cfg_wdata[STAT_W-1:0]),
        .abort_q (abort),
        .stat_q  (fault_status)
    );

endmodule

// File: rtl/domain_guard_chk.sv
module domain_guard_chk
    import dg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [DOM_W-1:0]  acc_dom,
    input logic              cfg_wr,
    input logic              cfg_sel,
    input logic              abort,
    input logic [STAT_W-1:0] fault_status,
    input logic [CTRL_W-1:0] ctrl_q
);

    logic [FLD_W-1:0] fld;
    assign fld = ctrl_q[{acc_dom, 1'b0} +: FLD_W];

    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        abort |-> $past(acc_valid)); // R8

    AST_BLOCKED_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && fld == 2'b00) |=> (abort && fault_status[STAT_W-1:CODE_W] == $past(acc_dom))); // R3

    AST_RSVD_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && fld == 2'b10) |=> abort); // R4

    AST_MANAGER_PASSES: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && fld == 2'b11) |=> !abort); // R5

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        abort |-> (fault_status[CODE_W-1:0] inside {4'h9, 4'hB, 4'hD, 4'hF})); // R7

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!abort && !($past(cfg_wr) && $past(cfg_sel))) |-> $stable(fault_status)); // R9

endmodule

bind domain_guard domain_guard_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_dom      (acc_dom),
    .cfg_wr       (cfg_wr),
    .cfg_sel      (cfg_sel),
    .abort        (abort),
    .fault_status (fault_status),
    .ctrl_q       (ctrl_q)
);

// File: tb/test_domain_guard.sv
`timescale 1ns/1ps
module test_domain_guard;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [3:0]  acc_dom;
    logic [1:0]  acc_ap;
    logic        acc_priv, acc_write, acc_page;
    logic        cfg_wr, cfg_sel;
    logic [31:0] cfg_wdata;
    logic        abort;
    logic [7:0]  fault_status;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    domain_guard i_domain_guard (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_dom(acc_dom),
        .acc_ap(acc_ap), .acc_priv(acc_priv), .acc_write(acc_write),
        .acc_page(acc_page), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .abort(abort), .fault_status(fault_status)
    );

    // Control word: domain d gets mode d%4 (00 blocked, 01 client, 10 reserved, 11 manager)
    localparam logic [31:0] PATTERN = 32'hE4E4_E4E4;

    // {dom, ap, priv, write, page, exp_abort, exp_status}
    localparam int NV = 14;
    localparam logic [17:0] VEC [NV] = '{
        {4'd0,  2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h09},  // R3 blocked, section
        {4'd4,  2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h4B},  // R3 blocked, page
        {4'd2,  2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 8'h29},  // R4 reserved
        {4'd3,  2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h29},  // R5 manager ignores AP
        {4'd15, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h29},  // R5 manager, top domain
        {4'd1,  2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h29},  // R6 full access
        {4'd1,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'h1D},  // R6 user write to read-only
        {4'd1,  2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'h1D},  // R6 user read allowed
        {4'd5,  2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h1D},  // R6 privileged write allowed
        {4'd5,  2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5F},  // R6 user on privileged-only page
        {4'd9,  2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5F},  // R6 privileged allowed
        {4'd13, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hDF},  // R6 no-access AP, page
        {4'd14, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'hE9},  // R4 reserved, domain 14
        {4'd12, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'hCB}   // R3 blocked, domain 12 page
    };

    task automatic step(input logic v, input logic [3:0] d, input logic [1:0] ap,
                        input logic p, input logic w, input logic pg,
                        input logic cw, input logic cs, input logic [31:0] wd);
        @(negedge clk);
        acc_valid = v; acc_dom = d; acc_ap = ap; acc_priv = p;
        acc_write = w; acc_page = pg; cfg_wr = cw; cfg_sel = cs; cfg_wdata = wd;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic check(input string tag, input logic exp_abt, input logic [7:0] exp_st);
        total++;
        if (abort !== exp_abt || fault_status !== exp_st) begin
            bad++;
            $display("FAIL %s: abort=%0b status=%02h expected abort=%0b status=%02h",
                     tag, abort, fault_status, exp_abt, exp_st);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        acc_valid = 0; acc_dom = 0; acc_ap = 0; acc_priv = 0; acc_write = 0;
        acc_page = 0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", 1'b0, 8'h00);
        @(negedge clk) rst = 1'b0;

        // R1: all domains blocked after reset
        step(1'b1, 4'd7, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R1 default blocks domain 7", 1'b1, 8'h79);
        idle();
        check("R8 abort lasts one cycle", 1'b0, 8'h79);

        // Table walk
        step(1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, PATTERN);
        for (int i = 0; i < NV; i++) begin
            logic [17:0] e;
            e = VEC[i];
            step(1'b1, e[17:14], e[13:12], e[11], e[10], e[9], 1'b0, 1'b0, 32'h0);
            check($sformatf("R6/R7 vector %0d", i), e[8], e[7:0]);
            idle();
            check($sformatf("R8/R9 vector %0d after", i), 1'b0, e[7:0]);
        end

        // R2: domain 1 only blocked
        step(1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFF3);
        step(1'b1, 4'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R2 domain 1 blocked -> 0x19", 1'b1, 8'h19);
        step(1'b1, 4'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R2 domain 0 manager", 1'b0, 8'h19);
        step(1'b1, 4'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
        check("R9 domain 2 manager keeps status", 1'b0, 8'h19);

        // R8: no valid, no abort
        step(1'b0, 4'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R8 invalid access ignored", 1'b0, 8'h19);

        // R10: status port write, then collision with abort
        step(1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_00A5);
        check("R10 status write", 1'b0, 8'hA5);
        step(1'b1, 4'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0033);
        check("R10 abort beats status write", 1'b1, 8'h1B);

        // R11: control write and access in one cycle
        step(1'b1, 4'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        check("R11 old word blocks domain 1", 1'b1, 8'h19);
        step(1'b1, 4'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R11 new word makes domain 1 manager", 1'b0, 8'h19);
        step(1'b1, 4'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFF3);
        check("R11 old manager word still applies", 1'b0, 8'h19);
        step(1'b1, 4'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
        check("R11 rewritten word blocks domain 1 page", 1'b1, 8'h1B);
        idle();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule